// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital sequencer of a high-speed CAN transceiver. Each clock it looks at the standby and silent control pins, the transmit data level, two supply-undervoltage flags and a recessive-clamp detector. From these it decides whether the transceiver is Unpowered, in Standby, Silent (receive only) or Normal. The analog parts are not modelled here. The bus driver, the high-speed comparator, the low-power wake comparator and the bus bias network are each reduced to one enable output that this block drives.

Changes of mode are not instantaneous. Each kind of hop has its own settling delay, given as a parameter in clock ticks. While a delay runs, the enables keep the values of the old mode. If the inputs point somewhere else before the delay is over, the count starts again toward the new destination.

One parameter picks between two variants. In the first, the silent pin is used and the I/O supply is tied to the core supply. In the second, there is a separate I/O supply flag and the silent pin reads as constant high.

Top module: `cantrx_mode_ctrl`

## Requirements
- R1: While reset is asserted and on its release, `mode_o` is 0 (Unpowered) and all four enables are low.
- R2: Unpowered is left only after the supplies have been good on 2 consecutive clock edges. The next mode is always Standby, entered on the second good edge.
- R3: A supply fault moves the block to Unpowered on the next edge, from any mode, whatever the levels of `stby_i` and the other pins. A supply fault means `vcc_uv_i` high, or, when `SILENT_PIN`=0, also `vio_uv_i` high. When `SILENT_PIN`=1, `vio_uv_i` has no effect.
- R4: With supplies good, `stby_i` high selects Standby (code 1), whatever `nsil_i`, `txd_i` and the fault state are.
- R5: `stby_i` low, effective silent pin high, `txd_i` high and no latched clamp fault select Normal (code 3). With `txd_i` low, the block stays in its current mode, so Standby is not left toward Normal.
- R6: With `SILENT_PIN`=1, `stby_i` low and `nsil_i` low select Silent (code 2), whatever `txd_i` is.
- R7: A new destination D is committed on the (T+1)-th rising edge after it first appears at the inputs, where T is `DLY_WAKE` from Standby to Silent or Normal, `DLY_SWAP` between Normal and Silent, and `DLY_SLEEP` from Normal or Silent to Standby. Until then, mode and enables keep their old values.
- R8: If the destination changes while a delay is running, the count restarts. Returning to the current mode cancels the pending hop.
- R9: In Silent or Normal, a high `clamp_det_i` latches a fault that forces Silent. The latch clears when `rxd_dom_i` is high, or in Standby or Unpowered. In Standby, `clamp_det_i` is ignored.
- R10: With `SILENT_PIN`=0, `nsil_i` is treated as 1. Silent is then reachable only through the clamp fault.
- R11: Mode code on `mode_o`: Unpowered 0, Standby 1, Silent 2, Normal 3. `tx_en_o` is high only in Normal. `hsrx_en_o` and `bias_mid_o` are high in Silent and Normal. `wake_en_o` is high only in Standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stby_i | input | 1 | Standby request pin level |
| nsil_i | input | 1 | Silent control pin level, low requests Silent |
| txd_i | input | 1 | Transmit data level from the protocol controller |
| vcc_uv_i | input | 1 | Core supply below threshold |
| vio_uv_i | input | 1 | I/O supply below threshold (used when SILENT_PIN=0) |
| clamp_det_i | input | 1 | Receiver reports dominant while RXD stays high |
| rxd_dom_i | input | 1 | RXD pin shows dominant |
| mode_o | output | 2 | Current mode code |
| tx_en_o | output | 1 | Bus transmitter enable |
| hsrx_en_o | output | 1 | High-speed receive path enable |
| wake_en_o | output | 1 | Low-power wake comparator enable |
| bias_mid_o | output | 1 | Bus biased to mid-supply (low: biased to ground) |

## Verification
The mode selection is swept over every combination of the standby, silent and transmit-data pins, starting from each of Standby, Silent and Normal. Each case checks the mode one edge before the expected hop and on the hop edge. This separates the three delay classes from each other, and it separates an input combination that must hold the current mode from one that must move it. Directed sequences then cover four cases:
- a one-cycle supply glitch, which must not end Unpowered;
- a destination withdrawn mid-delay, which must restart the count;
- a clamp pulse cleared by RXD, and one cleared by passing through Standby;
- the two variants driven side by side, where the silent pin and the I/O supply flag must each matter to only one of them.

// File: rtl/cantrx_mode_pkg.sv
package cantrx_mode_pkg;

  typedef enum logic [1:0] {
    MD_UNPWR   = 2'd0,
    MD_STANDBY = 2'd1,
    MD_SILENT  = 2'd2,
    MD_NORMAL  = 2'd3
  } trx_mode_e;

  // Destination mode for powered operation; txd low holds the present mode.
  function automatic trx_mode_e pick_target(trx_mode_e cur, logic stby,
                                            logic nsil, logic txd, logic fault);
    trx_mode_e t;
    if (stby)                t = MD_STANDBY;
    else if (!nsil || fault) t = MD_SILENT;
    else if (txd)            t = MD_NORMAL;
    else                     t = cur;
    return t;
  endfunction

  // Settling ticks for a hop between two powered modes.
  function automatic int unsigned hop_ticks(trx_mode_e from, trx_mode_e to,
                                            int unsigned wake, int unsigned swap,
                                            int unsigned sleep);
    int unsigned t;
    if (to == MD_STANDBY)        t = sleep;
    else if (from == MD_STANDBY) t = wake;
    else                         t = swap;
    return t;
  endfunction

endpackage

// File: rtl/cantrx_supply_qual.sv
module cantrx_supply_qual #(
  parameter bit          USE_VIO  = 1'b0,
  parameter int unsigned GOOD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_uv_i,
  input  logic vio_uv_i,
  output logic sup_ok_o,
  output logic sup_ready_o
);
  localparam int unsigned GW = (GOOD_CYC > 2) ? $clog2(GOOD_CYC) : 1;
  localparam logic [GW-1:0] GLAST = GW'(GOOD_CYC - 1);

  logic [GW-1:0] good_q;

  generate
    if (USE_VIO) begin : g_dual
      assign sup_ok_o = !vcc_uv_i && !vio_uv_i;
    end else begin : g_single
      logic unused_vio;
      assign unused_vio = vio_uv_i;
      assign sup_ok_o   = !vcc_uv_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !sup_ok_o) good_q <= '0;
    else if (good_q != GLAST) good_q <= good_q + GW'(1);
  end

  assign sup_ready_o = sup_ok_o && (good_q == GLAST);

  // R2
  good_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ready_o |-> $past(sup_ok_o));

endmodule

// File: rtl/cantrx_clamp_latch.sv
module cantrx_clamp_latch
  import cantrx_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trx_mode_e mode_i,
  input  logic      clamp_det_i,
  input  logic      rxd_dom_i,
  output logic      fault_o
);
  logic active_mode, drop_fault;

  assign active_mode = (mode_i == MD_SILENT) || (mode_i == MD_NORMAL);
  assign drop_fault  = rxd_dom_i || !active_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || drop_fault)        fault_o <= 1'b0;
    else if (clamp_det_i)            fault_o <= 1'b1;
  end

  // R9
  fault_sleep_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_STANDBY) |=> !fault_o);

  // R9
  fault_rxd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_dom_i |=> !fault_o);

endmodule

// File: rtl/cantrx_mode_seq.sv
module cantrx_mode_seq
  import cantrx_mode_pkg::*;
#(
  parameter int unsigned DLY_WAKE  = 6,
  parameter int unsigned DLY_SWAP  = 3,
  parameter int unsigned DLY_SLEEP = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sup_ok_i,
  input  logic      sup_ready_i,
  input  logic      stby_i,
  input  logic      nsil_i,
  input  logic      txd_i,
  input  logic      fault_i,
  output trx_mode_e mode_o
);
  localparam int unsigned MAXD0 = (DLY_WAKE > DLY_SWAP) ? DLY_WAKE : DLY_SWAP;
  localparam int unsigned MAXD  = (MAXD0 > DLY_SLEEP) ? MAXD0 : DLY_SLEEP;
  localparam int unsigned CW    = $clog2(MAXD + 1);

  trx_mode_e       mode_q, pend_q, tgt;
  logic [CW-1:0]   cnt_q, hop_last;
  logic            retarget, hop_done;

  assign tgt      = pick_target(mode_q, stby_i, nsil_i, txd_i, fault_i);
  assign hop_last = CW'(hop_ticks(mode_q, tgt, DLY_WAKE, DLY_SWAP, DLY_SLEEP)) - CW'(1);
  assign retarget = (tgt != mode_q) && (tgt != pend_q);
  assign hop_done = (tgt != mode_q) && (tgt == pend_q) && (cnt_q >= hop_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !sup_ok_i) begin
      mode_q <= MD_UNPWR;
      pend_q <= MD_UNPWR;
      cnt_q  <= '0;
    end else if (mode_q == MD_UNPWR) begin
      if (sup_ready_i) mode_q <= MD_STANDBY;
      pend_q <= MD_STANDBY;
      cnt_q  <= '0;
    end else if (tgt == mode_q) begin
      pend_q <= mode_q;
      cnt_q  <= '0;
    end else if (retarget) begin
      pend_q <= tgt;
      cnt_q  <= '0;
    end else if (hop_done) begin
      mode_q <= tgt;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign mode_o = mode_q;

  // R3
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok_i |=> (mode_q == MD_UNPWR));

  // R2
  unpwr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_UNPWR) |=> (mode_q inside {MD_UNPWR, MD_STANDBY}));

  // R4
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok_i && stby_i && mode_q == MD_STANDBY) |=> (mode_q == MD_STANDBY));

  // R5
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_NORMAL) |=> (mode_q != MD_NORMAL) || ($past(txd_i) && !$past(fault_i)));

  // R9
  fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && mode_q != MD_NORMAL) |=> (mode_q != MD_NORMAL));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXD));

endmodule

// File: rtl/cantrx_mode_ctrl.sv
module cantrx_mode_ctrl
  import cantrx_mode_pkg::*;
#(
  parameter bit          SILENT_PIN = 1'b1,
  parameter int unsigned DLY_WAKE   = 6,
  parameter int unsigned DLY_SWAP   = 3,
  parameter int unsigned DLY_SLEEP  = 2,
  parameter int unsigned GOOD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_i,
  input  logic       nsil_i,
  input  logic       txd_i,
  input  logic       vcc_uv_i,
  input  logic       vio_uv_i,
  input  logic       clamp_det_i,
  input  logic       rxd_dom_i,
  output logic [1:0] mode_o,
  output logic       tx_en_o,
  output logic       hsrx_en_o,
  output logic       wake_en_o,
  output logic       bias_mid_o
);
  logic      sup_ok, sup_ready, nsil_eff, fault;
  trx_mode_e mode;

  generate
    if (SILENT_PIN) begin : g_silpin
      assign nsil_eff = nsil_i;
    end else begin : g_iopin
      logic unused_nsil;
      assign unused_nsil = nsil_i;
      assign nsil_eff    = 1'b1;
    end
  endgenerate

  cantrx_supply_qual #(
    .USE_VIO  (!SILENT_PIN),
    .GOOD_CYC (GOOD_CYC)
  ) u_sup (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcc_uv_i    (vcc_uv_i),
    .vio_uv_i    (vio_uv_i),
    .sup_ok_o    (sup_ok),
    .sup_ready_o (sup_ready)
  );

  cantrx_clamp_latch u_clamp (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .clamp_det_i (clamp_det_i),
    .rxd_dom_i   (rxd_dom_i),
    .fault_o     (fault)
  );

  cantrx_mode_seq #(
    .DLY_WAKE  (DLY_WAKE),
    .DLY_SWAP  (DLY_SWAP),
    .DLY_SLEEP (DLY_SLEEP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_ok_i    (sup_ok),
    .sup_ready_i (sup_ready),
    .stby_i      (stby_i),
    .nsil_i      (nsil_eff),
    .txd_i       (txd_i),
    .fault_i     (fault),
    .mode_o      (mode)
  );

  assign mode_o     = mode;
  assign tx_en_o    = (mode == MD_NORMAL);
  assign hsrx_en_o  = (mode == MD_NORMAL) || (mode == MD_SILENT);
  assign bias_mid_o = (mode == MD_NORMAL) || (mode == MD_SILENT);
  assign wake_en_o  = (mode == MD_STANDBY);

  // R11
  tx_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(sup_ok) && hsrx_en_o);

endmodule

// File: tb/cantrx_mode_ctrl_tb.sv
`timescale 1ns/1ps
module cantrx_mode_ctrl_tb_top;
  localparam int UP = 6, NS = 3, DN = 2;

  logic clk = 1'b0;
  logic rst_n, stby, nsil, txd, vcc_uv, vio_uv, clamp, rxd_dom;
  logic [1:0] mode_a, mode_b;
  logic tx_a, hs_a, wk_a, bi_a, tx_b, hs_b, wk_b, bi_b;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  cantrx_mode_ctrl #(.SILENT_PIN(1'b1), .DLY_WAKE(UP), .DLY_SWAP(NS), .DLY_SLEEP(DN)) dut_i (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .nsil_i(nsil), .txd_i(txd),
    .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv), .clamp_det_i(clamp), .rxd_dom_i(rxd_dom),
    .mode_o(mode_a), .tx_en_o(tx_a), .hsrx_en_o(hs_a), .wake_en_o(wk_a), .bias_mid_o(bi_a));

  cantrx_mode_ctrl #(.SILENT_PIN(1'b0), .DLY_WAKE(UP), .DLY_SWAP(NS), .DLY_SLEEP(DN)) dut_b (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .nsil_i(nsil), .txd_i(txd),
    .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv), .clamp_det_i(clamp), .rxd_dom_i(rxd_dom),
    .mode_o(mode_b), .tx_en_o(tx_b), .hsrx_en_o(hs_b), .wake_en_o(wk_b), .bias_mid_o(bi_b));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Enables as {tx, hsrx, wake, bias} from the mode code table (R11).
  function automatic int en_word(int m);
    return ((m == 3) ? 8 : 0) + ((m >= 2) ? 4 : 0) + ((m == 1) ? 2 : 0) + ((m >= 2) ? 1 : 0);
  endfunction

  task automatic chk_a(string req, int exp);
    chk(req, int'(mode_a), exp);
    chk({req, " R11 enables"}, int'({tx_a, hs_a, wk_a, bi_a}), en_word(exp));
  endtask

  task automatic chk_b(string req, int exp);
    chk({req, " io-variant"}, int'(mode_b), exp);
    chk({req, " io-variant R11 enables"}, int'({tx_b, hs_b, wk_b, bi_b}), en_word(exp));
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int want(int s, bit sb, bit ns, bit tx);
    if (sb) return 1;
    if (!ns) return 2;
    if (tx) return 3;
    return s;
  endfunction

  function automatic int ticks(int a, int b);
    if (b == 1) return DN;
    if (a == 1) return UP;
    return NS;
  endfunction

  task automatic goto_mode(int m);
    stby = 1'b1; nsil = 1'b1; txd = 1'b1;
    edges(DN + 2);
    if (m != 1) begin
      stby = 1'b0; nsil = (m == 3); txd = 1'b1;
      edges(UP + 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stby = 1'b1; nsil = 1'b1; txd = 1'b1;
    vcc_uv = 1'b0; vio_uv = 1'b0; clamp = 1'b0; rxd_dom = 1'b0;
    edges(3);
    chk_a("R1 reset", 0);
    chk_b("R1 reset", 0);

    rst_n = 1'b1;
    edges(1); chk_a("R2 one good edge", 0);
    edges(1); chk_a("R2 two good edges", 1); chk_b("R2 two good edges", 1);

    vcc_uv = 1'b1; edges(1); chk_a("R3 vcc loss", 0);
    vcc_uv = 1'b0; edges(1); chk_a("R2 glitch one good", 0);
    vcc_uv = 1'b1; edges(1); chk_a("R3 glitch loss", 0);
    vcc_uv = 1'b0; edges(2); chk_a("R2 recovered", 1);

    for (int s = 1; s <= 3; s++) begin
      for (int c = 0; c < 8; c++) begin
        int e, d;
        goto_mode(s);
        chk_a("R7 sweep setup", s);
        stby = c[2]; nsil = c[1]; txd = c[0];
        e = want(s, c[2], c[1], c[0]);
        if (e == s) begin
          edges(UP + 2);
          chk_a((e == 1) ? "R4 hold" : "R5 hold", s);
        end else begin
          d = ticks(s, e);
          edges(d);
          chk_a("R7 before hop", s);
          edges(1);
          chk_a((e == 1) ? "R4 hop" : ((e == 2) ? "R6 hop" : "R5 hop"), e);
        end
      end
    end

    goto_mode(1);
    stby = 1'b0; nsil = 1'b1; txd = 1'b1;
    edges(3);
    stby = 1'b1; edges(2); chk_a("R8 cancel", 1);
    stby = 1'b0;
    edges(UP); chk_a("R8 restart not early", 1);
    edges(1);  chk_a("R8 restart hop", 3);
    chk_b("R8 restart hop", 3);

    clamp = 1'b1; edges(1); clamp = 1'b0;
    edges(NS); chk_a("R9 fault before hop", 3);
    edges(1);  chk_a("R9 fault forces silent", 2);
    chk_b("R10 fault silent", 2);
    rxd_dom = 1'b1; edges(1); rxd_dom = 1'b0;
    edges(NS); chk_a("R9 clear before hop", 2);
    edges(1);  chk_a("R9 rxd clears fault", 3);

    clamp = 1'b1; edges(1); clamp = 1'b0;
    edges(NS + 2); chk_a("R9 fault again", 2);
    stby = 1'b1; edges(DN + 2); chk_a("R9 standby", 1);
    stby = 1'b0; edges(UP + 2); chk_a("R9 standby cleared fault", 3);

    stby = 1'b1; edges(DN + 2);
    clamp = 1'b1; edges(1); clamp = 1'b0;
    stby = 1'b0; edges(UP + 2); chk_a("R9 clamp ignored in standby", 3);

    nsil = 1'b0; edges(NS + 2);
    chk_a("R6 silent pin", 2);
    chk_b("R10 silent pin ignored", 3);
    nsil = 1'b1; edges(NS + 2);

    vio_uv = 1'b1; edges(1);
    chk_b("R3 vio loss", 0);
    chk_a("R3 vio ignored", 3);
    vio_uv = 1'b0; edges(2); chk_b("R2 vio recovered", 1);
    edges(UP + 2); chk_b("R5 io-variant normal", 3);

    vcc_uv = 1'b1; stby = 1'b0; edges(1);
    stby = 1'b1; edges(1); stby = 1'b0; edges(2);
    chk_a("R3 stby ignored while unpowered", 0);
    chk_b("R3 stby ignored while unpowered", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule